// File: doc/BRIEF.md
# Subvector-Grouped Predicated Add Loop

This block runs an element loop that adds two operand vectors held in an external element store and writes the sums back to it. The loop works on groups rather than single scalars. Each group is a short packed vector of one to four scalars, and the vector length counts groups. One predicate bit per group decides whether every lane of that group is computed and written, or none of them. The predicate sense can be inverted, so that a group runs when its bit is clear.

A caller presents three base indices (first source, second source, destination), the group size, an element-width code, the group count, the predicate mask and the invert flag, and pulses `start`. The block latches these values and then issues one scalar per cycle to the store's two read ports. It writes each sum through the store's write port one cycle later. The store has a fixed read latency of one cycle and no back-pressure, so the loop never stalls. A group whose predicate is off costs a single cycle and touches the store not at all. A one-cycle `done` pulse marks the end of the run.

Top module: `grp_sub_alu`

## Requirements
- R1: With S = `subvl_m1`+1 (1 to 4), lane j of group i reads the first source at `src1_base`+i*S+j and the second at `src2_base`+i*S+j, and writes the sum to `dst_base`+i*S+j. Lanes are issued in order of rising j within rising i.
- R2: The sum wraps modulo the element width and has no carry out. `ew_sel` 0 selects 8 bits, 1 selects 16, and 2 or 3 select 32. Bits above the width are written as zero.
- R3: Bit i of `pred_mask` (bit 0 belongs to group 0) enables all lanes of group i together. When `pred_inv` is 1, the group runs when that bit is 0.
- R4: A disabled group costs exactly one cycle, issues no read and no write, and leaves its destination elements unchanged.
- R5: Read data is taken in the cycle after `rd_en`, and the matching write is presented in that same cycle.
- R6: `done` is high for exactly one cycle, 1+N cycles after the edge that accepts `start`. N is S times the number of enabled groups plus the number of disabled groups. With `vl` = 0, `done` comes in the first cycle after acceptance.
- R7: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle, and a `start` held during a run has no effect.
- R8: During reset, `busy`, `done`, `rd_en` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted when not busy |
| src1_base | input | ADDR_W | Base index of first operand vector |
| src2_base | input | ADDR_W | Base index of second operand vector |
| dst_base | input | ADDR_W | Base index of result vector |
| subvl_m1 | input | 2 | Scalars per group minus one |
| ew_sel | input | 2 | Element width code |
| vl | input | VL_W | Number of groups (clamped to VL_MAX) |
| pred_mask | input | VL_MAX | One enable bit per group |
| pred_inv | input | 1 | Invert predicate sense |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_en | output | 1 | Read request to both store read ports |
| rd_addr_a | output | ADDR_W | First operand read index |
| rd_addr_b | output | ADDR_W | Second operand read index |
| rd_data_a | input | DATA_W | First operand data, one cycle after rd_en |
| rd_data_b | input | DATA_W | Second operand data, one cycle after rd_en |
| wr_en | output | 1 | Write strobe to the store |
| wr_addr | output | ADDR_W | Write index |
| wr_data | output | DATA_W | Width-masked sum |

## Verification
Each write is due exactly one cycle after the read that feeds it. The `done` pulse is due 1+N cycles after the accepting edge. N is computed by the bench from the group size and the predicate pattern. The driver pushes every expected write, in issue order, into a queue. A monitor compares each `wr_en` cycle against the queue head mid-cycle, so order, address and width masking are all checked as they appear. The driver counts cycles from the accepting edge to `done`, then checks that the queue has drained and that the destinations of disabled groups still hold their preloaded values.

// File: rtl/grp_alu_pkg.sv
package grp_alu_pkg;
  localparam int SUBVL_MAX = 4;
  localparam int EW_CODES  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/grp_loop_seq.sv
module grp_loop_seq
  import grp_alu_pkg::*;
#(
  parameter int VL_MAX = 16,
  parameter int VL_W   = $clog2(VL_MAX + 1),
  parameter int OFF_W  = $clog2(VL_MAX * SUBVL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [1:0]        subvl_m1,
  input  logic [VL_W-1:0]   vl,
  input  logic [VL_MAX-1:0] pred_mask,
  input  logic              pred_inv,
  output logic              busy,
  output logic              done,
  output logic              issue,
  output logic [OFF_W-1:0]  off
);
  seq_st_e           st;
  logic [VL_W-1:0]   grp_q;
  logic [VL_W-1:0]   vl_q;
  logic [1:0]        lane_q;
  logic [1:0]        sub_q;
  logic [VL_MAX-1:0] mask_q;
  logic              inv_q;
  logic              grp_on, lane_last, grp_end, grp_last;

  always_comb begin
    grp_on    = mask_q[0] ^ inv_q;
    lane_last = (lane_q == sub_q);
    grp_end   = !grp_on || lane_last;
    grp_last  = (grp_q == vl_q - 1'b1);
  end

  assign issue = (st == ST_RUN) && grp_on;
  assign busy  = (st != ST_IDLE);
  assign done  = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      grp_q  <= '0;
      vl_q   <= '0;
      lane_q <= '0;
      sub_q  <= '0;
      mask_q <= '0;
      inv_q  <= 1'b0;
      off    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            vl_q   <= (vl > VL_W'(VL_MAX)) ? VL_W'(VL_MAX) : vl;
            mask_q <= pred_mask;
            inv_q  <= pred_inv;
            sub_q  <= subvl_m1;
            grp_q  <= '0;
            lane_q <= '0;
            off    <= '0;
            st     <= (vl == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (grp_end) begin
            lane_q <= '0;
            grp_q  <= grp_q + 1'b1;
            mask_q <= mask_q >> 1;
            if (grp_last) st <= ST_DONE;
          end else begin
            lane_q <= lane_q + 1'b1;
          end
          off <= off + (grp_on ? OFF_W'(1) : (OFF_W'(sub_q) + OFF_W'(1)));
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/grp_lane_add.sv
module grp_lane_add
  import grp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        ew,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] keep [EW_CODES];

  for (genvar g = 0; g < EW_CODES; g++) begin : g_keep
    localparam int NARROW = 8 << g;
    localparam int BITS   = (g >= 2 || NARROW > DATA_W) ? DATA_W : NARROW;
    assign keep[g] = {DATA_W{1'b1}} >> (DATA_W - BITS);
  end

  assign y = (a + b) & keep[ew];
endmodule

// File: rtl/grp_sub_alu.sv
module grp_sub_alu
  import grp_alu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int VL_MAX = 16,
  parameter int VL_W   = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src1_base,
  input  logic [ADDR_W-1:0] src2_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [1:0]        subvl_m1,
  input  logic [1:0]        ew_sel,
  input  logic [VL_W-1:0]   vl,
  input  logic [VL_MAX-1:0] pred_mask,
  input  logic              pred_inv,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr_a,
  output logic [ADDR_W-1:0] rd_addr_b,
  input  logic [DATA_W-1:0] rd_data_a,
  input  logic [DATA_W-1:0] rd_data_b,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int OFF_W = $clog2(VL_MAX * SUBVL_MAX + 1);

  logic              accept;
  logic              issue;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] s1_q, s2_q, d_q;
  logic [1:0]        ew_q;
  logic              wv_q;
  logic [ADDR_W-1:0] wa_q;

  assign accept = start && !busy;

  grp_loop_seq #(
    .VL_MAX (VL_MAX),
    .VL_W   (VL_W),
    .OFF_W  (OFF_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .subvl_m1  (subvl_m1),
    .vl        (vl),
    .pred_mask (pred_mask),
    .pred_inv  (pred_inv),
    .busy      (busy),
    .done      (done),
    .issue     (issue),
    .off       (off)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      d_q  <= '0;
      ew_q <= '0;
    end else if (accept) begin
      s1_q <= src1_base;
      s2_q <= src2_base;
      d_q  <= dst_base;
      ew_q <= ew_sel;
    end
  end

  assign rd_en     = issue;
  assign rd_addr_a = s1_q + ADDR_W'(off);
  assign rd_addr_b = s2_q + ADDR_W'(off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
      wa_q <= '0;
    end else begin
      wv_q <= issue;
      wa_q <= d_q + ADDR_W'(off);
    end
  end

  grp_lane_add #(.DATA_W(DATA_W)) u_add (
    .ew (ew_q),
    .a  (rd_data_a),
    .b  (rd_data_b),
    .y  (wr_data)
  );

  assign wr_en   = wv_q;
  assign wr_addr = wa_q;
endmodule

// File: rtl/grp_sub_alu_chk.sv
module grp_sub_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        ew_q
);
  logic [DATA_W-1:0] keep;

  always_comb begin
    case (ew_q)
      2'd0:    keep = DATA_W'(8'hFF);
      2'd1:    keep = DATA_W'(16'hFFFF);
      default: keep = {DATA_W{1'b1}};
    endcase
  end

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en)); // R5
  AST_WIDTH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~keep) == '0)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en); // R6
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_en && !wr_en)); // R7
endmodule

bind grp_sub_alu grp_sub_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .ew_q    (ew_q)
);

// File: tb/tb_grp_sub_alu.sv
`timescale 1ns/1ps
module tb_grp_sub_alu;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int VM = 16;
  localparam int VW = $clog2(VM + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src1_base = '0, src2_base = '0, dst_base = '0;
  logic [1:0]    subvl_m1 = '0, ew_sel = '0;
  logic [VW-1:0] vl = '0;
  logic [VM-1:0] pred_mask = '0;
  logic          pred_inv = 1'b0;
  logic          busy, done, rd_en, wr_en;
  logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data;

  logic          load = 1'b0;
  logic [31:0]   seed = '0;
  logic [DW-1:0] mem [256];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t exp_q[$];
  int  seen_wr = 0;

  always #10 clk = ~clk;

  grp_sub_alu #(.ADDR_W(AW), .DATA_W(DW), .VL_MAX(VM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src1_base(src1_base), .src2_base(src2_base), .dst_base(dst_base),
    .subvl_m1(subvl_m1), .ew_sel(ew_sel), .vl(vl),
    .pred_mask(pred_mask), .pred_inv(pred_inv),
    .busy(busy), .done(done), .rd_en(rd_en),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] fill_val(logic [31:0] s, int k);
    return (32'(k) * 32'h9E3779B1) ^ s ^ (32'(k) << 24);
  endfunction

  // element store model: one-cycle read latency
  always @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < 256; k++) mem[k] <= fill_val(seed, k);
    end else begin
      if (rd_en) begin
        rd_data_a <= mem[rd_addr_a];
        rd_data_b <= mem[rd_addr_b];
      end
      if (wr_en) mem[wr_addr] <= wr_data;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops expected writes as the design presents them
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      seen_wr++;
      if (exp_q.size() == 0) begin
        check(0, "R3", "unexpected write addr", longint'(wr_addr), 0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check(wr_addr == e.a, "R1", "write address", longint'(wr_addr), longint'(e.a));
        check(wr_data == e.d, "R2 R5", "write data", longint'(wr_data), longint'(e.d));
      end
    end
  end

  task automatic run(input logic [AW-1:0] a1, a2, ad, input int sub, input logic [1:0] ew,
                     input int nvl, input logic [VM-1:0] msk, input bit inv,
                     input logic [31:0] sd, input int hold);
    int n_cyc;
    int n_wr;
    int cyc;
    logic [DW-1:0] keep;
    keep = (ew == 2'd0) ? 32'hFF : (ew == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    @(negedge clk); seed = sd; load = 1'b1;
    @(negedge clk); load = 1'b0;
    n_cyc = 0; n_wr = 0;
    for (int g = 0; g < nvl; g++) begin
      if (msk[g] ^ inv) begin
        for (int j = 0; j < sub; j++) begin
          wr_t e;
          int o;
          o = g * sub + j;
          e.a = ad + AW'(o);
          e.d = (fill_val(sd, int'(a1) + o) + fill_val(sd, int'(a2) + o)) & keep;
          exp_q.push_back(e);
          n_cyc++; n_wr++;
        end
      end else begin
        n_cyc++;
      end
    end
    seen_wr = 0;
    src1_base = a1; src2_base = a2; dst_base = ad;
    subvl_m1 = 2'(sub - 1); ew_sel = ew; vl = VW'(nvl);
    pred_mask = msk; pred_inv = inv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc = 1;
    if (hold == 0) start = 1'b0;
    check(busy == 1'b1, "R7", "busy after accept", longint'(busy), 1);
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc > hold) start = 1'b0;
    end
    start = 1'b0;
    check(cyc == 1 + n_cyc, "R6", "done latency", cyc, 1 + n_cyc);
    @(negedge clk);
    check(done == 1'b0, "R6", "done width", longint'(done), 0);
    check(busy == 1'b0, "R7", "busy after done", longint'(busy), 0);
    check(seen_wr == n_wr, "R3", "write count", seen_wr, n_wr);
    check(exp_q.size() == 0, "R1", "writes left", exp_q.size(), 0);
    for (int g = 0; g < nvl; g++) begin
      if (!(msk[g] ^ inv)) begin
        for (int j = 0; j < sub; j++) begin
          int o;
          o = int'(ad) + g * sub + j;
          check(mem[o] == fill_val(sd, o), "R4", "masked dest changed",
                longint'(mem[o]), longint'(fill_val(sd, o)));
        end
      end
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_en && !wr_en, "R8", "reset outputs",
          longint'({busy, done, rd_en, wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(8'h00, 8'h40, 8'h80, 3, 2'd1, 5,  16'b10110, 1'b0, 32'h1234_5678, 0);
    run(8'h00, 8'h40, 8'h80, 3, 2'd1, 5,  16'b10110, 1'b1, 32'h0BAD_F00D, 3);
    run(8'h10, 8'h60, 8'hA0, 1, 2'd0, 12, 16'h0A5F,  1'b0, 32'hFFFF_FF80, 0);
    run(8'h00, 8'h40, 8'h80, 4, 2'd2, 16, 16'hFFFF,  1'b0, 32'h5555_AAAA, 0);
    run(8'h00, 8'h40, 8'h80, 2, 2'd1, 0,  16'hFFFF,  1'b0, 32'h0000_0001, 0);
    run(8'h00, 8'h40, 8'h80, 2, 2'd1, 4,  16'h0000,  1'b0, 32'h7777_0000, 0);
    run(8'h00, 8'h40, 8'h80, 4, 2'd3, 16, 16'h8001,  1'b1, 32'hC001_D00D, 2);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule